// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for an I2C master from the peripheral clock. Two 16-bit count inputs set the length of each phase. One sets how many peripheral clock cycles SCL is pulled low. The other sets how many cycles it is released high. The bit period is therefore the sum of the two counts. Because the counts are independent, the duty cycle can be asymmetric. For example, at a 10 MHz peripheral clock, a sum of 100 gives 100 kHz, a sum of 25 gives 400 kHz and a sum of 10 gives 1 MHz. A count below 4 is raised to 4.

The drive is open-drain in style. `scl_drive_low` pulls the line down, and otherwise the line is released. The generator reads the line back on `scl_in` and starts timing the high phase only once it sees the line high. A slave can therefore stretch the clock by holding SCL low. Two one-cycle strobes tell the data shifter when SCL is released and when it is pulled low. New count values are taken up at the start of each low phase, so a bit in progress keeps its timing.

Top module: `scl_gen`

## Requirements
- R1: During reset, and in every cycle after a clock edge at which `enable` was low, `scl_drive_low`, `rise_stb` and `fall_stb` are all 0.
- R2: After a clock edge at which `enable` is first seen high following a disabled period, `scl_drive_low` is 1 in the next cycle, so every bit begins with its low phase.
- R3: Each low phase lasts exactly max(4, `low_count`) cycles of `scl_drive_low` = 1.
- R4: Without stretching, the line is released for exactly max(4, `high_count`) cycles, and consecutive `fall_stb` pulses are max(4,`low_count`) + max(4,`high_count`) cycles apart.
- R5: A count value of 0 to 3 behaves exactly like a value of 4.
- R6: Unequal low and high counts produce phases of the corresponding unequal lengths within one bit.
- R7: After release, cycles in which `scl_in` reads 0 do not count toward the high phase. The release lasts for those stretch cycles plus max(4,`high_count`) cycles, and SCL is never pulled low while a stretched line is still low.
- R8: `rise_stb` is 1 for exactly the first released cycle after a low phase, and it is never 1 in the same cycle as `fall_stb`.
- R9: `fall_stb` is 1 exactly in the first cycle of each low phase, coinciding with the rising edge of `scl_drive_low`.
- R10: `low_count` and `high_count` are sampled only at the clock edge that starts a low phase. Changes made at any other time alter neither the current low phase nor the high phase that follows it.
- R11: Dropping `enable` in the middle of a bit releases SCL at the next edge. Re-enabling starts a complete new low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator when high; when low, SCL is released and the counters are cleared |
| low_count | input | 16 | Low phase length in peripheral clock cycles (values below 4 act as 4) |
| high_count | input | 16 | High phase length in peripheral clock cycles (values below 4 act as 4) |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| rise_stb | output | 1 | One-cycle pulse in the first cycle SCL is released |
| fall_stb | output | 1 | One-cycle pulse in the first cycle SCL is pulled low |

## Verification
The assertions assume that `scl_in` follows the block's own drive: the line is low whenever `scl_drive_low` is 1. They also assume that an external device holds the line low only from the first released cycle of a bit and then lets it go for the rest of that high phase. Under that assumption the assertions can require at least four high cycles before each new low phase. The bench wires `scl_in` as the inverse of the drive, ANDed with a stretch signal. It raises stretch only in response to `rise_stb`, and only for a fixed number of cycles. In this way the stretching it injects stays inside the assumed model.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_REL  = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // Raise a programmed phase length to the hardware floor.
  function automatic int unsigned floor_count(int unsigned raw, int unsigned min_v);
    return (raw < min_v) ? min_v : raw;
  endfunction

  // Counter preload when a low phase starts: the count runs down to zero inclusive.
  function automatic int unsigned low_reload(int unsigned raw, int unsigned min_v);
    return floor_count(raw, min_v) - 1;
  endfunction

  // Counter preload when the line is first seen high: the release cycle
  // that observed the high level already counts as one high cycle.
  function automatic int unsigned high_reload(int unsigned floored);
    return floored - 2;
  endfunction

endpackage

// File: rtl/scl_hold_reg.sv
module scl_hold_reg
  import scl_gen_pkg::*;
#(
  parameter int W       = 16,
  parameter int MIN_CNT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] RESET_VAL = W'(MIN_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RESET_VAL;
    end else if (capture) begin
      q <= W'(floor_count(32'(d), 32'(MIN_CNT)));
    end
  end

endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         is_zero
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ZERO;
    end else if (clear) begin
      cnt <= ZERO;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != ZERO) begin
      cnt <= cnt - ONE;
    end
  end

  assign is_zero = (cnt == ZERO);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       scl_in,
  input  logic       cnt_zero,
  output scl_phase_e phase,
  output logic       go_low,
  output logic       go_rel,
  output logic       go_high,
  output logic       rise_q,
  output logic       fall_q
);

  scl_phase_e phase_nx;

  always_comb begin
    go_low  = enable && ((phase == PH_IDLE) || ((phase == PH_HIGH) && cnt_zero));
    go_rel  = enable && (phase == PH_LOW) && cnt_zero;
    go_high = enable && (phase == PH_REL) && scl_in;

    if (!enable)      phase_nx = PH_IDLE;
    else if (go_low)  phase_nx = PH_LOW;
    else if (go_rel)  phase_nx = PH_REL;
    else if (go_high) phase_nx = PH_HIGH;
    else              phase_nx = phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      phase  <= phase_nx;
      rise_q <= go_rel;
      fall_q <= go_low;
    end
  end

endmodule

// File: rtl/scl_gen.sv
module scl_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             rise_stb,
  output logic             fall_stb
);

  scl_phase_e       phase;
  logic             cnt_zero;
  logic             go_low;
  logic             go_rel;
  logic             go_high;
  logic [CNT_W-1:0] high_held;
  logic [CNT_W-1:0] load_val;
  logic             cnt_load;
  logic             cnt_clear;

  scl_phase_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .scl_in   (scl_in),
    .cnt_zero (cnt_zero),
    .phase    (phase),
    .go_low   (go_low),
    .go_rel   (go_rel),
    .go_high  (go_high),
    .rise_q   (rise_stb),
    .fall_q   (fall_stb)
  );

  // High length is frozen at the start of each low phase.
  scl_hold_reg #(.W(CNT_W), .MIN_CNT(MIN_CNT)) u_high_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (go_low),
    .d       (high_count),
    .q       (high_held)
  );

  always_comb begin
    if (go_low) load_val = CNT_W'(low_reload(32'(low_count), 32'(MIN_CNT)));
    else        load_val = CNT_W'(high_reload(32'(high_held)));
  end

  assign cnt_load  = go_low | go_high;
  assign cnt_clear = ~enable;

  scl_phase_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .load     (cnt_load),
    .load_val (load_val),
    .is_zero  (cnt_zero)
  );

  assign scl_drive_low = (phase == PH_LOW);

endmodule

// File: rtl/scl_gen_chk.sv
module scl_gen_chk #(
  parameter int MIN_CNT = 4
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_in,
  input logic scl_drive_low,
  input logic rise_stb,
  input logic fall_stb
);

  int unsigned low_run;
  int unsigned hi_run;
  logic        in_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= 0;
      hi_run  <= 0;
      in_bit  <= 1'b0;
    end else begin
      low_run <= scl_drive_low ? low_run + 1 : 0;
      hi_run  <= (rise_stb ? 0 : hi_run) + ((scl_in && !scl_drive_low) ? 1 : 0);
      if (!enable)       in_bit <= 1'b0;
      else if (rise_stb) in_bit <= 1'b1;
    end
  end

  // R1
  disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !rise_stb && !fall_stb));

  // R9
  fall_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> $rose(scl_drive_low));

  // R9
  edge_has_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> fall_stb);

  // R8
  rise_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> $fell(scl_drive_low));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb}));

  // R3
  low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (low_run >= MIN_CNT));

  // R4
  high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && in_bit) |-> (hi_run >= MIN_CNT));

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !scl_drive_low && !scl_in) |=> !scl_drive_low);

endmodule

bind scl_gen scl_gen_chk #(.MIN_CNT(MIN_CNT)) u_chk (.*);

// File: tb/scl_gen_test.sv
module scl_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] low_count = 16'd10;
  logic [15:0] high_count = 16'd10;
  logic        stretch = 1'b0;
  logic        scl_drive_low, rise_stb, fall_stb;
  wire         scl_in = ~scl_drive_low & ~stretch;

  always #2 clk = ~clk;

  scl_gen uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .low_count     (low_count),
    .high_count    (high_count),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .rise_stb      (rise_stb),
    .fall_stb      (fall_stb)
  );

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  string tag = "R1";
  int    stretch_cfg = 0;
  int    stretch_left = 0;
  int    exp_period = 0;
  int    prev_fall = -1;
  bit    done = 0;

  // Behavioural reference: mode 0 off, 1 pulling low, 2 released waiting, 3 released counting
  int m_mode = 0;
  int m_elapsed = 0;
  int m_lo = 4;
  int m_hi = 4;
  bit m_drive = 0, m_rise = 0, m_fall = 0;

  function automatic int at_least4(int v);
    return (v < 4) ? 4 : v;
  endfunction

  task automatic model_step();
    bit line_high;
    line_high = !m_drive && !stretch;
    m_rise = 0;
    m_fall = 0;
    if (!rst_n || !enable) begin
      m_mode = 0;
    end else begin
      case (m_mode)
        0: begin
          m_mode = 1; m_elapsed = 0; m_fall = 1;
          m_lo = at_least4(int'(low_count)); m_hi = at_least4(int'(high_count));
        end
        1: begin
          m_elapsed++;
          if (m_elapsed == m_lo) begin m_mode = 2; m_rise = 1; end
        end
        2: if (line_high) begin m_mode = 3; m_elapsed = 1; end
        default: begin
          m_elapsed++;
          if (m_elapsed >= m_hi) begin
            m_mode = 1; m_elapsed = 0; m_fall = 1;
            m_lo = at_least4(int'(low_count)); m_hi = at_least4(int'(high_count));
          end
        end
      endcase
    end
    m_drive = (m_mode == 1);
  endtask

  task automatic compare();
    checks++;
    if (scl_drive_low !== m_drive || rise_stb !== m_rise || fall_stb !== m_fall) begin
      fails++;
      $display("FAIL %s cycle %0d: drive/rise/fall actual %b%b%b expected %b%b%b",
               tag, cyc, scl_drive_low, rise_stb, fall_stb, m_drive, m_rise, m_fall);
    end
    if (fall_stb === 1'b1) begin
      if (exp_period != 0 && prev_fall >= 0) begin
        checks++;
        if (cyc - prev_fall != exp_period) begin
          fails++;
          $display("FAIL R4 (%s) cycle %0d: bit period actual %0d expected %0d",
                   tag, cyc, cyc - prev_fall, exp_period);
        end
      end
      prev_fall = cyc;
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_step();
      compare();
      if (stretch_left > 0) begin
        stretch = 1'b1; stretch_left--;
      end else begin
        stretch = 1'b0;
      end
      if (rise_stb === 1'b1 && stretch_cfg > 0) begin
        stretch = 1'b1; stretch_left = stretch_cfg - 1;
      end
      cyc++;
    end
  endtask

  task automatic setup(string t, int lo, int hi, int period);
    tag = t;
    low_count = 16'(lo);
    high_count = 16'(hi);
    exp_period = period;
    prev_fall = -1;
  endtask

  initial begin
    // R1: reset and disabled state
    tag = "R1";
    tick(3);
    rst_n = 1'b1;
    tick(20);
    // R2 R3 R4: symmetric, sum 10 and sum 100
    enable = 1'b1;
    setup("R2 R3 R4", 5, 5, 10);
    tick(60);
    setup("R3 R4", 50, 50, 100);
    tick(420);
    // R6: asymmetric duty (15 low, 10 high)
    setup("R6", 15, 10, 25);
    tick(140);
    setup("R6", 7, 19, 26);
    tick(140);
    // R5: counts below the floor act as 4
    setup("R5", 0, 2, 8);
    tick(60);
    setup("R5", 3, 1, 8);
    tick(60);
    // R7: slave stretches 3 cycles after every release
    setup("R7", 6, 5, 0);
    stretch_cfg = 3;
    tick(10);
    exp_period = 14;
    tick(100);
    stretch_cfg = 9;
    setup("R7", 4, 4, 0);
    tick(80);
    stretch_cfg = 0;
    tick(20);
    // R10: counts changed mid-bit apply from the next low phase only
    setup("R10", 8, 8, 0);
    tick(40);
    for (int k = 0; k < 12; k++) begin
      low_count = 16'(20 + k);
      high_count = 16'(5 + k);
      tick(3);
    end
    setup("R10", 12, 6, 0);
    tick(5);
    setup("R10", 30, 4, 0);
    tick(80);
    // R11: disable mid-bit and restart
    setup("R11", 10, 10, 0);
    tick(33);
    enable = 1'b0;
    tick(6);
    enable = 1'b1;
    tick(50);
    enable = 1'b0;
    tick(3);
    enable = 1'b1;
    tick(40);
    // R1: disable again and hold off
    tag = "R1";
    enable = 1'b0;
    tick(20);
    // R1: reset in the middle of activity
    enable = 1'b1;
    setup("R1", 6, 6, 0);
    tick(17);
    rst_n = 1'b0;
    tick(4);
    rst_n = 1'b1;
    setup("R2", 6, 6, 12);
    tick(50);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual cycle %0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule